// File: doc/BRIEF.md
# Fault Brake Controller for a PWM Channel Pair

This block watches a set of fault sources and, when one of them is armed and active, overrides the two PWM outputs of one channel pair with a programmable safe level. The sources are two analog comparator outputs, two external brake pins, a flag from an ADC result monitor, and a group of four system-failure signals. Each source has its own enable for each of two brake kinds. A latched brake stays on after its cause goes away, until software clears it. A following brake lasts only while its cause is present.

Each brake pin passes through an optional inverter and then a glitch filter. The filter samples the pin at the system clock divided by a power of two, and accepts a new level only after it has seen that level on a programmed number of consecutive samples. Software can also request either kind of brake through a 16-bit trigger word. Each pair has its own bit in that word, and a pair-select input tells the block which bits belong to it.

Top module: `fault_brake_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `edge_brk`, `level_brk` and `level_flag` are 0 and `pwm_out` equals `pwm_in`.
- R2: The source index is bit 0 comparator 0, bit 1 comparator 1, bit 2 pin 0, bit 3 pin 1, bit 4 ADC monitor, bit 5 system failure. If a source is high and its `edge_en` bit is set at a clock edge, `edge_brk` is 1 after that edge. `edge_brk` then stays 1 until an edge where `edge_clr` is high and no set condition is present. When a set condition and `edge_clr` occur in the same cycle, the set wins.
- R3: After each clock edge, `level_brk` is 1 exactly when some source with its `level_en` bit set was high at that edge, or when the software level request was high at that edge.
- R4: The system-failure source is high only when some bit of `sys_fail_in` is high and the same bit of `sys_sel` is set. The bits are: 0 clock-security detect, 1 brown-out, 2 SRAM parity error, 3 core lockup. Any other failure bit has no effect.
- R5: The bit `sw_trig[pair_sel]` acts as a latched-brake set. The bit `sw_trig[8+pair_sel]` acts as a following-brake source for one cycle. No other bit of `sw_trig` has any effect on this pair.
- R6: When `pin_inv[i]` is 1, brake pin i is treated as active while it is low.
- R7: With `flt_en` at 0, a pin reaches the brake logic with no filter delay. With `flt_en` at 1 and `flt_div` at 0, a new pin level held from before edge 1 is accepted at edge `flt_len`+1, and the brake follows one edge later. A pulse shorter than `flt_len`+1 cycles is never accepted.
- R8: The filter takes one sample every 2^`flt_div` clock cycles. With `flt_div`=2 and `flt_len`=1, a 2-cycle pin pulse causes no brake, and a level held for 20 cycles does cause one.
- R9: While `edge_brk` or `level_brk` is 1, `pwm_out` equals `safe_lvl` in that same cycle. Otherwise `pwm_out` equals `pwm_in`.
- R10: `level_flag` becomes 1 in the same cycle as `level_brk`. It stays 1 until an edge where `level_clr` is high and `level_brk` is not being set. When a set and `level_clr` occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_sel | input | 3 | Which software trigger bit pair this instance answers |
| cmp_in | input | 2 | Comparator outputs, active high |
| pin_in | input | 2 | External brake pins |
| adc_mon_in | input | 1 | ADC result monitor flag |
| sys_fail_in | input | 4 | System failure signals |
| edge_en | input | 6 | Latched-brake enable per source |
| level_en | input | 6 | Following-brake enable per source |
| sys_sel | input | 4 | Per-failure qualifier for the system source |
| pin_inv | input | 2 | Invert each brake pin |
| flt_en | input | 1 | Enable the pin glitch filter |
| flt_div | input | 3 | Filter sample divider exponent |
| flt_len | input | 3 | Consecutive samples needed, minus one |
| sw_trig | input | 16 | Software brake request word (pulse) |
| edge_clr | input | 1 | Clear the latched brake |
| level_clr | input | 1 | Clear the following-brake flag |
| pwm_in | input | 2 | PWM pair from the waveform generator |
| safe_lvl | input | 2 | Levels forced during a brake |
| pwm_out | output | 2 | PWM pair after brake override |
| edge_brk | output | 1 | Latched brake active |
| level_brk | output | 1 | Following brake active |
| level_flag | output | 1 | Sticky following-brake flag |

## Verification
A set condition and a software clear can fall in the same cycle. This happens for the latched brake (a source or a software set against `edge_clr`) and for the following-brake flag (`level_brk` against `level_clr`). Random stimulus drives the clear inputs about a quarter of the time while sources toggle freely, so the two often coincide. A directed case also holds comparator 0 high under a clear. In every cycle, a bench model in which the set wins decides the expected latch and flag values. The output override in the same cycle is compared against that model in every cycle as well.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_CMP0 = 0;
  localparam int SRC_CMP1 = 1;
  localparam int SRC_PIN0 = 2;
  localparam int SRC_PIN1 = 3;
  localparam int SRC_ADC  = 4;
  localparam int SRC_SYS  = 5;
  localparam int SYS_W    = 4;
  localparam int NPIN     = 2;
  localparam int NOUT     = 2;
endpackage

// File: rtl/brk_prescale.sv
module brk_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + PRE_W'(1);
  end

  // mask has div_sel low bits set; a wrap of the shift at the top code yields all ones
  always_comb begin
    mask = (PRE_W'(1) << div_sel) - PRE_W'(1);
    tick = ((pre_cnt & mask) == mask);
  end
endmodule

// File: rtl/brk_pin_filter.sv
module brk_pin_filter #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             inv,
  input  logic             en,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             lvl
);
  logic             raw;
  logic             stable;
  logic [LEN_W-1:0] run;

  assign raw = pin ^ inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      stable <= 1'b0;
      run    <= '0;
    end else if (!en) begin
      stable <= raw;
      run    <= '0;
    end else if (tick) begin
      if (raw != stable) begin
        if (run == len) begin
          stable <= raw;
          run    <= '0;
        end else begin
          run <= run + LEN_W'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end

  assign lvl = en ? stable : raw;
endmodule

// File: rtl/fault_brake_ctrl.sv
module fault_brake_ctrl
  import brk_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int LEN_W   = 3,
  parameter int LVL_OFS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             pair_sel,
  input  logic [1:0]             cmp_in,
  input  logic [NPIN-1:0]        pin_in,
  input  logic                   adc_mon_in,
  input  logic [SYS_W-1:0]       sys_fail_in,
  input  logic [NSRC-1:0]        edge_en,
  input  logic [NSRC-1:0]        level_en,
  input  logic [SYS_W-1:0]       sys_sel,
  input  logic [NPIN-1:0]        pin_inv,
  input  logic                   flt_en,
  input  logic [DIV_W-1:0]       flt_div,
  input  logic [LEN_W-1:0]       flt_len,
  input  logic [2*LVL_OFS-1:0]   sw_trig,
  input  logic                   edge_clr,
  input  logic                   level_clr,
  input  logic [NOUT-1:0]        pwm_in,
  input  logic [NOUT-1:0]        safe_lvl,
  output logic [NOUT-1:0]        pwm_out,
  output logic                   edge_brk,
  output logic                   level_brk,
  output logic                   level_flag
);
  localparam int SW_W  = 2 * LVL_OFS;
  localparam int IDX_W = $clog2(SW_W);

  logic             tick;
  logic [NPIN-1:0]  pin_lvl;
  logic [NSRC-1:0]  src;
  logic [IDX_W-1:0] edge_idx;
  logic [IDX_W-1:0] lvl_idx;
  logic             sw_edge;
  logic             sw_lvl;
  logic             edge_set;
  logic             lvl_next;

  brk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .div_sel (flt_div),
    .tick    (tick)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    brk_pin_filter #(.LEN_W(LEN_W)) u_flt (
      .clk  (clk),
      .rst  (rst),
      .pin  (pin_in[p]),
      .inv  (pin_inv[p]),
      .en   (flt_en),
      .tick (tick),
      .len  (flt_len),
      .lvl  (pin_lvl[p])
    );
  end

  always_comb begin
    src           = '0;
    src[SRC_CMP0] = cmp_in[0];
    src[SRC_CMP1] = cmp_in[1];
    src[SRC_PIN0] = pin_lvl[0];
    src[SRC_PIN1] = pin_lvl[1];
    src[SRC_ADC]  = adc_mon_in;
    src[SRC_SYS]  = |(sys_fail_in & sys_sel);
  end

  assign edge_idx = IDX_W'(pair_sel);
  assign lvl_idx  = IDX_W'(LVL_OFS) + IDX_W'(pair_sel);
  assign sw_edge  = sw_trig[edge_idx];
  assign sw_lvl   = sw_trig[lvl_idx];
  assign edge_set = (|(src & edge_en)) | sw_edge;
  assign lvl_next = (|(src & level_en)) | sw_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_brk   <= 1'b0;
      level_brk  <= 1'b0;
      level_flag <= 1'b0;
    end else begin
      edge_brk   <= edge_set | (edge_brk & ~edge_clr);
      level_brk  <= lvl_next;
      level_flag <= lvl_next | (level_flag & ~level_clr);
    end
  end

  assign pwm_out = (edge_brk | level_brk) ? safe_lvl : pwm_in;
endmodule

// File: rtl/fault_brake_ctrl_chk.sv
module fault_brake_ctrl_chk #(
  parameter int SW_W = 16,
  parameter int LVL_OFS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      pair_sel,
  input logic [SW_W-1:0] sw_trig,
  input logic            edge_clr,
  input logic [1:0]      pwm_out,
  input logic [1:0]      safe_lvl,
  input logic            edge_brk,
  input logic            level_brk,
  input logic            level_flag
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!edge_brk && !level_brk && !level_flag)); // R1

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (edge_brk && !edge_clr) |=> edge_brk); // R2

  AST_SW_EDGE: assert property (@(posedge clk) disable iff (rst)
    sw_trig[pair_sel] |=> edge_brk); // R5

  AST_SW_LEVEL: assert property (@(posedge clk) disable iff (rst)
    sw_trig[LVL_OFS + 32'(pair_sel)] |=> level_brk); // R5

  AST_FLAG_WITH_BRAKE: assert property (@(posedge clk) disable iff (rst)
    level_brk |-> level_flag); // R10

  AST_SAFE_FORCE: assert property (@(posedge clk) disable iff (rst)
    (edge_brk || level_brk) |-> (pwm_out == safe_lvl)); // R9
endmodule

bind fault_brake_ctrl fault_brake_ctrl_chk #(.SW_W(2*LVL_OFS), .LVL_OFS(LVL_OFS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pair_sel   (pair_sel),
  .sw_trig    (sw_trig),
  .edge_clr   (edge_clr),
  .pwm_out    (pwm_out),
  .safe_lvl   (safe_lvl),
  .edge_brk   (edge_brk),
  .level_brk  (level_brk),
  .level_flag (level_flag)
);

// File: tb/tb_fault_brake_ctrl.sv
`timescale 1ns/1ps
module tb_fault_brake_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  pair_sel;
  logic [1:0]  cmp_in;
  logic [1:0]  pin_in;
  logic        adc_mon_in;
  logic [3:0]  sys_fail_in;
  logic [5:0]  edge_en;
  logic [5:0]  level_en;
  logic [3:0]  sys_sel;
  logic [1:0]  pin_inv;
  logic        flt_en;
  logic [2:0]  flt_div;
  logic [2:0]  flt_len;
  logic [15:0] sw_trig;
  logic        edge_clr;
  logic        level_clr;
  logic [1:0]  pwm_in;
  logic [1:0]  safe_lvl;
  logic [1:0]  pwm_out;
  logic        edge_brk;
  logic        level_brk;
  logic        level_flag;

  int errors = 0;
  int checks = 0;
  logic m_edge, m_lvl, m_flag;

  always #4 clk = ~clk;

  fault_brake_ctrl dut (.*);

  function automatic logic [5:0] src_vec();
    logic [1:0] rp;
    rp = pin_in ^ pin_inv;
    return {|(sys_fail_in & sys_sel), adc_mon_in, rp[1], rp[0], cmp_in[1], cmp_in[0]};
  endfunction

  function automatic logic lvl_req();
    return (|(src_vec() & level_en)) | sw_trig[8 + int'(pair_sel)];
  endfunction

  function automatic logic edge_req();
    return (|(src_vec() & edge_en)) | sw_trig[pair_sel];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, then the outputs are read at the falling edge
  task automatic cyc();
    logic e, l, f, rq;
    @(posedge clk);
    if (rst) begin
      e = 0; l = 0; f = 0;
    end else begin
      rq = lvl_req();
      e = edge_req() | (m_edge & ~edge_clr);
      l = rq;
      f = rq | (m_flag & ~level_clr);
    end
    m_edge = e; m_lvl = l; m_flag = f;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 edge_brk"}, 8'(edge_brk), 8'(m_edge));
    chk({tag, " R3 level_brk"}, 8'(level_brk), 8'(m_lvl));
    chk({tag, " R10 level_flag"}, 8'(level_flag), 8'(m_flag));
    chk({tag, " R9 pwm_out"}, 8'(pwm_out), 8'((m_edge | m_lvl) ? safe_lvl : pwm_in));
  endtask

  task automatic quiet();
    cmp_in = 0; pin_in = 0; adc_mon_in = 0; sys_fail_in = 0; sw_trig = 0;
    pin_inv = 0; edge_clr = 0; level_clr = 0;
  endtask

  task automatic clear_all();
    quiet();
    edge_clr = 1; level_clr = 1;
    cyc();
    edge_clr = 0; level_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_edge = 0; m_lvl = 0; m_flag = 0;
    quiet();
    rst = 1; pair_sel = 3'd2; edge_en = 0; level_en = 0; sys_sel = 0;
    flt_en = 0; flt_div = 0; flt_len = 0; pwm_in = 2'b10; safe_lvl = 2'b01;
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    // R1 reset state
    chk("R1 edge_brk", 8'(edge_brk), 0);
    chk("R1 level_brk", 8'(level_brk), 0);
    chk("R1 level_flag", 8'(level_flag), 0);
    chk("R1 pwm_out", 8'(pwm_out), 8'(pwm_in));
    cyc(); check_all("R1 post");

    // R4 system failure gating
    level_en = 6'b100000; edge_en = 0;
    sys_fail_in = 4'b1011; sys_sel = 4'b0100;
    cyc(); check_all("R4 unselected");
    chk("R4 no brake", 8'(level_brk), 0);
    sys_fail_in = 4'b0100;
    cyc(); check_all("R4 selected");
    chk("R4 brake", 8'(level_brk), 1);
    sys_sel = 0;
    cyc(); chk("R4 sel off", 8'(level_brk), 0);
    clear_all(); check_all("R4 clr");

    // R5 software trigger, own bits vs others (pair_sel = 2)
    edge_en = 0; level_en = 0;
    sw_trig = 16'h0202;
    cyc(); check_all("R5 foreign");
    chk("R5 foreign edge", 8'(edge_brk), 0);
    chk("R5 foreign level", 8'(level_brk), 0);
    sw_trig = 16'h0400;
    cyc(); chk("R5 own level", 8'(level_brk), 1);
    sw_trig = 0;
    cyc(); chk("R5 level one cycle", 8'(level_brk), 0);
    sw_trig = 16'h0004;
    cyc(); sw_trig = 0; chk("R5 own edge", 8'(edge_brk), 1);
    cyc(); check_all("R5 edge held");
    clear_all();

    // R2 set against clear in the same cycle
    edge_en = 6'b000001; cmp_in = 2'b01;
    cyc(); cmp_in = 2'b00; cyc(); check_all("R2 latched");
    chk("R2 latched after source gone", 8'(edge_brk), 1);
    cmp_in = 2'b01; edge_clr = 1;
    cyc(); chk("R2 set wins over clear", 8'(edge_brk), 1);
    cmp_in = 0;
    cyc(); chk("R2 clear releases", 8'(edge_brk), 0);
    edge_clr = 0;

    // R6 inversion with filter off
    level_en = 6'b001000; edge_en = 0; pin_inv = 2'b10; pin_in = 2'b00;
    cyc(); chk("R6 inverted low pin brakes", 8'(level_brk), 1);
    pin_in = 2'b10;
    cyc(); chk("R6 inverted high pin idle", 8'(level_brk), 0);
    clear_all();

    // random mix, filter off
    for (int i = 0; i < 3000; i++) begin
      cmp_in      = 2'(($urandom % 4 == 0) ? $urandom : 0);
      pin_in      = 2'($urandom);
      pin_inv     = 2'(($urandom % 3 == 0) ? 3 : 0);
      adc_mon_in  = ($urandom % 5 == 0);
      sys_fail_in = 4'(($urandom % 4 == 0) ? $urandom : 0);
      sys_sel     = 4'($urandom);
      edge_en     = 6'(($urandom % 3 == 0) ? $urandom : 0);
      level_en    = 6'($urandom);
      sw_trig     = ($urandom % 6 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      edge_clr    = ($urandom % 4 == 0);
      level_clr   = ($urandom % 4 == 0);
      pwm_in      = 2'($urandom);
      safe_lvl    = 2'($urandom);
      pair_sel    = 3'($urandom);
      cyc();
      check_all("rand");
    end

    // filter tests; expected cycles counted from the requirements
    quiet(); edge_en = 0; level_en = 6'b000100; pair_sel = 0;
    flt_en = 1; flt_div = 0; flt_len = 3;
    clear_all(); cyc();
    pin_in = 2'b01;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R7 not before len+2 edges", 8'(level_brk), 0);
    @(posedge clk); @(negedge clk); chk("R7 accepted", 8'(level_brk), 1);
    pin_in = 0; repeat (8) @(posedge clk); @(negedge clk);
    chk("R7 release", 8'(level_brk), 0);
    pin_in = 2'b01; repeat (3) @(posedge clk); @(negedge clk);
    pin_in = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 short pulse rejected", 8'(level_brk), 0);
    end
    flt_en = 0; pin_in = 2'b01;
    @(posedge clk); @(negedge clk); chk("R7 bypass immediate", 8'(level_brk), 1);
    pin_in = 0; @(posedge clk); @(negedge clk);

    // R8 divided sampling
    flt_en = 1; flt_div = 2; flt_len = 1;
    repeat (4) @(posedge clk); @(negedge clk);
    pin_in = 2'b01; repeat (2) @(posedge clk); @(negedge clk); pin_in = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 2-cycle pulse rejected", 8'(level_brk), 0);
    end
    pin_in = 2'b01; repeat (20) @(posedge clk); @(negedge clk);
    chk("R8 held level accepted", 8'(level_brk), 1);
    chk("R9 forced safe level", 8'(pwm_out), 8'(safe_lvl));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule